// File: doc/BRIEF.md
# ALU status flag update unit

This block holds the five condition flags of a small processor core: carry (C), auxiliary carry (AC), overflow (V), negative (N) and zero (Z). On each cycle the execute stage presents an operation-class code, an operand-size select, the result value, the per-bit carry chain of the adder, the bit shifted out by a shifter, the upper half of a product, the divisor, and a divide-overflow indication. When the update strobe is high, the unit decides which flags the class may change, computes their new values and registers them. Flags that the class does not select keep their previous value.

Software can load the flag byte directly through a write port. The write port takes priority over an update in the same cycle. The three reserved bits are always stored as zero. The flag byte layout is C at bit 7, AC at bit 6, reserved bits 5 to 3, V at bit 2, N at bit 1 and Z at bit 0.

The class codes are: 0 none, 1 add/add-with-carry/subtract/subtract-with-borrow/compare, 2 decimal adjust, 3 negate, 4 shift/rotate, 5 multiply, 6 divide, 7 data move, 8 stack/sign-extend/address-load/exchange. Codes 9 to 15 change nothing. The size select is 0 for byte and 1 for word.

Top module: `flag_unit`

## Requirements
- R1: While rst_ni is low, flags_o reads 0x00.
- R2: For class 1, C takes carry_i[msb], AC takes carry_i[3], V takes carry_i[msb] XOR carry_i[msb-1], N takes res_i[msb], and Z is set exactly when the result bits 0..msb are all zero.
- R3: msb is 7 when size_i is 0 and 15 when size_i is 1. In byte size, result bits above bit 7 do not affect N or Z.
- R4: For class 2, C, N and Z update as in R2, and AC and V hold.
- R5: For class 3, V, N and Z update as in R2, and C and AC hold.
- R6: For class 4, C takes shout_i, N and Z update as in R2, and AC and V hold.
- R7: For class 5, C is cleared, V is set exactly when hi_i bits 0..msb are not all zero, N and Z update as in R2, and AC holds.
- R8: For class 6, C is cleared and V is set when dovf_i is high or when divsr_i bits 0..msb are all zero. N and Z update as in R2, and AC holds.
- R9: Class 7 updates only N and Z as in R2. Class 0, class 8 and codes 9 to 15 leave all flags unchanged.
- R10: When wr_i is high, the next flags_o equals wdata_i AND 0xC7, whatever upd_i is. Bits 5 to 3 of flags_o always read zero.
- R11: With wr_i and upd_i both low, flags_o holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Direct write of the flag byte |
| wdata_i | input | 8 | Flag byte to write |
| upd_i | input | 1 | Flag update strobe |
| op_i | input | 4 | Operation class code |
| size_i | input | 1 | Operand size select: 0 byte, 1 word |
| res_i | input | 16 | Result or transferred value |
| carry_i | input | 16 | Carry out of each adder bit position |
| shout_i | input | 1 | Bit shifted out by a shift or rotate |
| hi_i | input | 16 | Upper half of the product |
| divsr_i | input | 16 | Divisor operand |
| dovf_i | input | 1 | Quotient does not fit the destination |
| flags_o | output | 8 | Flag byte {C, AC, 0, 0, 0, V, N, Z} |

## Verification
The assertions assume that the inputs are stable between clock edges. They also assume that the carry vector, the product upper half and the divisor are considered only up to the selected operand size, so the checker applies the same byte or word view. The bench drives every input on the falling edge and chooses op_i from all sixteen codes, including the undefined ones. It mixes write and update strobes, sometimes in the same cycle. A reference model built from integer arithmetic predicts each next flag byte, and the bench compares against it after every rising edge.

// File: rtl/flag_pkg.sv
package flag_pkg;
  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_ARITH = 4'd1,
    OP_DADJ  = 4'd2,
    OP_NEG   = 4'd3,
    OP_SHIFT = 4'd4,
    OP_MUL   = 4'd5,
    OP_DIV   = 4'd6,
    OP_MOVE  = 4'd7,
    OP_KEEP  = 4'd8
  } op_cls_e;

  localparam int FLAG_W = 8;
  localparam int C_POS  = 7;
  localparam int AC_POS = 6;
  localparam int V_POS  = 2;
  localparam int N_POS  = 1;
  localparam int Z_POS  = 0;
  localparam logic [FLAG_W-1:0] RSV_MASK = 8'b0011_1000;

  typedef struct packed {
    logic c;
    logic ac;
    logic v;
    logic n;
    logic z;
  } flag_set_t;
endpackage

// File: rtl/flag_eval.sv
module flag_eval
  import flag_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op_i,
  input  logic          size_i,
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] carry_i,
  input  logic          shout_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] divsr_i,
  input  logic          dovf_i,
  output flag_set_t     val_o,
  output flag_set_t     en_o
);
  localparam int BW = DW / 2;

  logic [DW-1:0] size_mask;
  logic sign, zero, cout, cin, nib, upper_nz, div_zero;
  op_cls_e op;

  assign op        = op_cls_e'(op_i);
  assign size_mask = size_i ? {DW{1'b1}} : {{(DW-BW){1'b0}}, {BW{1'b1}}};
  assign sign      = size_i ? res_i[DW-1]   : res_i[BW-1];
  assign cout      = size_i ? carry_i[DW-1] : carry_i[BW-1];
  assign cin       = size_i ? carry_i[DW-2] : carry_i[BW-2];
  assign nib       = carry_i[3];
  assign zero      = ((res_i & size_mask) == '0);
  assign upper_nz  = |(hi_i & size_mask);
  assign div_zero  = ((divsr_i & size_mask) == '0);

  always_comb begin
    val_o = '{c: cout, ac: nib, v: cout ^ cin, n: sign, z: zero};
    en_o  = '0;
    unique case (op)
      OP_ARITH: en_o = '{c: 1'b1, ac: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1};
      OP_DADJ:  en_o = '{c: 1'b1, ac: 1'b0, v: 1'b0, n: 1'b1, z: 1'b1};
      OP_NEG:   en_o = '{c: 1'b0, ac: 1'b0, v: 1'b1, n: 1'b1, z: 1'b1};
      OP_SHIFT: begin
        en_o    = '{c: 1'b1, ac: 1'b0, v: 1'b0, n: 1'b1, z: 1'b1};
        val_o.c = shout_i;
      end
      OP_MUL: begin
        en_o    = '{c: 1'b1, ac: 1'b0, v: 1'b1, n: 1'b1, z: 1'b1};
        val_o.c = 1'b0;
        val_o.v = upper_nz;
      end
      OP_DIV: begin
        en_o    = '{c: 1'b1, ac: 1'b0, v: 1'b1, n: 1'b1, z: 1'b1};
        val_o.c = 1'b0;
        val_o.v = dovf_i | div_zero;
      end
      OP_MOVE:  en_o = '{c: 1'b0, ac: 1'b0, v: 1'b0, n: 1'b1, z: 1'b1};
      default:  en_o = '0;
    endcase
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  logic              upd_i,
  input  flag_set_t         val_i,
  input  flag_set_t         en_i,
  output logic [FLAG_W-1:0] q_o
);
  logic [FLAG_W-1:0] q_d, q_q, upd_byte;

  always_comb begin
    upd_byte        = q_q;
    if (en_i.c)  upd_byte[C_POS]  = val_i.c;
    if (en_i.ac) upd_byte[AC_POS] = val_i.ac;
    if (en_i.v)  upd_byte[V_POS]  = val_i.v;
    if (en_i.n)  upd_byte[N_POS]  = val_i.n;
    if (en_i.z)  upd_byte[Z_POS]  = val_i.z;
  end

  always_comb begin
    if (wr_i)       q_d = wdata_i & ~RSV_MASK;
    else if (upd_i) q_d = upd_byte & ~RSV_MASK;
    else            q_d = q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          upd_i,
  input  logic [3:0]    op_i,
  input  logic          size_i,
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] carry_i,
  input  logic          shout_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] divsr_i,
  input  logic          dovf_i,
  output logic [7:0]    flags_o
);
  flag_set_t val, en;

  flag_eval #(.DW(DW)) i_eval (
    .op_i    (op_i),
    .size_i  (size_i),
    .res_i   (res_i),
    .carry_i (carry_i),
    .shout_i (shout_i),
    .hi_i    (hi_i),
    .divsr_i (divsr_i),
    .dovf_i  (dovf_i),
    .val_o   (val),
    .en_o    (en)
  );

  flag_reg i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .upd_i   (upd_i),
    .val_i   (val),
    .en_i    (en),
    .q_o     (flags_o)
  );
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flag_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [7:0]    wdata_i,
  input logic          upd_i,
  input logic [3:0]    op_i,
  input logic          size_i,
  input logic [DW-1:0] divsr_i,
  input logic          dovf_i,
  input logic [7:0]    flags_o
);
  localparam int BW = DW / 2;
  logic dz;
  assign dz = size_i ? (divsr_i == '0) : (divsr_i[BW-1:0] == '0);

  // R10
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> flags_o == ($past(wdata_i) & 8'hC7));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !upd_i) |=> $stable(flags_o));

  // R9
  keep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && upd_i && op_i >= 4'd8) |=> $stable(flags_o));

  // R7
  mul_clr_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && upd_i && op_i == OP_MUL) |=> !flags_o[C_POS]);

  // R8
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && upd_i && op_i == OP_DIV && (dz || dovf_i)) |=> flags_o[V_POS] && !flags_o[C_POS]);

  // R5
  neg_hold_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && upd_i && op_i == OP_NEG) |=> $stable(flags_o[7:6]));

  // R1
  always @(posedge clk_i)
    if (!rst_ni) rst_zero_chk: assert (flags_o == 8'h00);
endmodule

bind flag_unit flag_unit_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_flag_unit.sv
`timescale 1ns/1ps
module test_flag_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, upd_i = 1'b0, size_i = 1'b0, shout_i = 1'b0, dovf_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [3:0]  op_i = '0;
  logic [15:0] res_i = '0, carry_i = '0, hi_i = '0, divsr_i = '0;
  logic [7:0]  flags_o;

  int n_run = 0, n_fail = 0;
  int model = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  flag_unit i_flag_unit (.*);

  function automatic int predict(int cur, bit wr, int wd, bit upd, int op, bit sz,
                                 int res, int cy, bit so, int hi, int dv, bit dov);
    int msb = sz ? 15 : 7;
    int lim = 1 << (msb + 1);
    int c  = (cur >> 7) & 1, a = (cur >> 6) & 1, v = (cur >> 2) & 1;
    int ng = (cur >> 1) & 1, zr = cur & 1;
    int rn = (res >> msb) & 1;
    int rz = ((res % lim) == 0) ? 1 : 0;
    int co = (cy >> msb) & 1;
    int ci = (cy >> (msb - 1)) & 1;
    int nb = (cy >> 3) & 1;
    if (wr) return wd & 199;
    if (!upd) return cur;
    case (op)
      1: begin c = co; a = nb; v = (co != ci); ng = rn; zr = rz; end
      2: begin c = co; ng = rn; zr = rz; end
      3: begin v = (co != ci); ng = rn; zr = rz; end
      4: begin c = so; ng = rn; zr = rz; end
      5: begin c = 0; v = ((hi % lim) != 0); ng = rn; zr = rz; end
      6: begin c = 0; v = (dov || (dv % lim) == 0); ng = rn; zr = rz; end
      7: begin ng = rn; zr = rz; end
      default: ;
    endcase
    return c * 128 + a * 64 + v * 4 + ng * 2 + zr;
  endfunction

  function automatic string tag_of(bit wr, bit upd, int op);
    if (wr) return "R10";
    if (!upd) return "R11";
    case (op)
      1: return "R2"; 2: return "R4"; 3: return "R5"; 4: return "R6";
      5: return "R7"; 6: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, int exp);
    n_run++;
    if (int'(flags_o) != exp) begin
      n_fail++;
      $display("FAIL %s: flags_o=%02h expected=%02h", tag, flags_o, exp[7:0]);
    end
  endtask

  task automatic step(bit wr, int wd, bit upd, int op, bit sz, int res, int cy,
                      bit so, int hi, int dv, bit dov, string tag);
    wr_i = wr; wdata_i = wd[7:0]; upd_i = upd; op_i = op[3:0]; size_i = sz;
    res_i = res[15:0]; carry_i = cy[15:0]; shout_i = so; hi_i = hi[15:0];
    divsr_i = dv[15:0]; dovf_i = dov;
    model = predict(model, wr, wd & 255, upd, op, sz, res & 65535, cy & 65535,
                    so, hi & 65535, dv & 65535, dov);
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, model);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: flags_o=%02h expected=done", flags_o);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", 0);  // R1 reset value
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 write masks reserved bits; write beats update
    step(1, 255, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R10");
    step(1, 8'h3A, 1, 1, 0, 0, 16'hFFFF, 0, 0, 1, 0, "R10");
    step(0, 0, 0, 1, 0, 0, 16'hFFFF, 0, 0, 1, 0, "R11");
    // R2 byte add: bit7 carry 0, bit6 carry 1, nibble carry 1, result 0x80
    step(0, 0, 1, 1, 0, 16'h0080, 16'h0048, 0, 0, 1, 0, "R2");
    // R3 word: carry 15 and 14, result zero
    step(0, 0, 1, 1, 1, 16'h0000, 16'hC000, 0, 0, 1, 0, "R3");
    // R3 byte ignores upper result bits for Z and N
    step(0, 0, 1, 7, 0, 16'hFF00, 0, 0, 0, 1, 0, "R3");
    step(0, 0, 1, 7, 1, 16'hFF00, 0, 0, 0, 1, 0, "R3");
    step(0, 0, 1, 2, 0, 16'h0001, 16'h0080, 0, 0, 1, 0, "R4");
    step(0, 0, 1, 3, 0, 16'h0080, 16'h0040, 0, 0, 1, 0, "R5");
    step(0, 0, 1, 4, 1, 16'h8000, 0, 1, 0, 1, 0, "R6");
    step(0, 0, 1, 5, 0, 16'h0010, 0, 0, 16'h0100, 1, 0, "R7");
    step(0, 0, 1, 5, 1, 16'h0010, 0, 0, 16'h0100, 1, 0, "R7");
    step(0, 0, 1, 6, 0, 16'h0005, 0, 0, 0, 16'h0100, 0, "R8");
    step(0, 0, 1, 6, 1, 16'h0005, 0, 0, 0, 16'h0100, 0, "R8");
    step(0, 0, 1, 6, 1, 16'h0005, 0, 0, 0, 16'h0100, 1, "R8");
    step(1, 8'hC7, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R10");
    step(0, 0, 1, 8, 1, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 12, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 600; i++) begin
      bit wr = ($urandom % 10) == 0;
      bit up = ($urandom % 4) != 0;
      int op = $urandom % 16;
      int dv = (($urandom % 4) == 0) ? ($urandom % 2) * 256 : $urandom % 65536;
      step(wr, $urandom % 256, up, op, $urandom % 2, $urandom % 65536,
           $urandom % 65536, $urandom % 2, (($urandom % 2) == 0) ? 0 : $urandom % 65536,
           dv, $urandom % 2, tag_of(wr, up, op));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule